// File: doc/BRIEF.md
# Sliced 16-bit Adder Unit with Status Flags

This block is the arithmetic core of a small 16-bit datapath. It is made of four identical 4-bit adder slices that ripple their carries from the lowest slice upward. Two controls shape the operands inside each slice. The first inverts operand A bit by bit. The second inverts operand B through a row of XOR gates, with no selector between B and its complement.

The carry into the lowest slice is its own input and is never derived from the subtract control. A two's-complement subtract therefore needs the surrounding controller to raise both the subtract control and the carry input. Raising only the subtract control gives A plus the one's complement of B. That form is useful for multi-word arithmetic.

Beside the 16-bit result, the unit reports eight flags: the final carry, the three carries passed between slices, zero, operand equality, negative and signed overflow. The negative flag follows the result sign in signed mode. In unsigned compare mode it follows the inverted final carry, so that a branch on "less than" can test one flag in either mode. The unit holds no state, and every output settles in the same cycle as its inputs.

Top module: `sliced_adder16`

## Requirements
- R1: `res` equals (`inv_a` ? ~`opa` : `opa`) + (`opb` XOR {16{`sub_en`}}) + `cin`, taken modulo 2^16.
- R2: `sub_en` leaves the carry input untouched: with `sub_en`=1 and `cin`=0 the result is A + ~B, which is one less than A − B. With `cin`=1 it is A − B.
- R3: `flg_c` is the carry out of result bit 15 of the addition in R1.
- R4: `flg_qc`, `flg_hc` and `flg_tc` are the carries out of bits 3, 7 and 11 of that addition, in that order.
- R5: `flg_z` is 1 exactly when `res` is 16'h0000.
- R6: `flg_eq` is 1 exactly when the port values `opa` and `opb` are equal, whatever `sub_en`, `inv_a`, `cin` and `cmp_unsigned` are.
- R7: With `cmp_unsigned`=0, `flg_n` equals `res[15]`.
- R8: With `cmp_unsigned`=1, `flg_n` equals the inverse of `flg_c`.
- R9: `flg_o` is 1 exactly when the two addends after inversion have the same sign and `res` has the other sign. An example is 32668 + 400, which gives 16'h812C with `flg_o`=1.
- R10: The unit is purely combinational. All outputs follow a change of the inputs with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| sub_en | input | 1 | Inverts B through XOR gates |
| inv_a | input | 1 | Inverts A through NOT gates |
| cin | input | 1 | Carry into the lowest slice |
| cmp_unsigned | input | 1 | 1 selects the unsigned meaning of the negative flag |
| res | output | 16 | Sum |
| flg_c | output | 1 | Carry out of bit 15 |
| flg_qc | output | 1 | Carry out of bit 3 |
| flg_hc | output | 1 | Carry out of bit 7 |
| flg_tc | output | 1 | Carry out of bit 11 |
| flg_z | output | 1 | Result is zero |
| flg_eq | output | 1 | Operands are equal |
| flg_n | output | 1 | Negative / unsigned below |
| flg_o | output | 1 | Signed overflow |

## Verification
The result and every flag are due zero cycles after a stimulus, because no register lies between the inputs and any output. The bench applies each vector on a falling clock edge and reads the outputs one nanosecond after the next rising edge. By then the ripple through all four slices has long settled, and the read cannot race an edge. The flag values are computed in the bench with 17-bit integer sums, separately for the 4-, 8-, 12- and 16-bit prefixes. They are then compared field by field, and each field is tagged with its requirement.

// File: rtl/sliced_adder_pkg.sv
// Shared sizing for the sliced adder unit.
// Assumes the slice count is at least four, so that the quarter,
// half and three-quarter carries exist.
package sliced_adder_pkg;
    parameter int SLICE_W   = 4;
    parameter int SLICE_CNT = 4;
    localparam int DATA_W   = SLICE_W * SLICE_CNT;
endpackage

// File: rtl/adder_slice.sv
// One ripple-carry adder slice.
// Operand A may be inverted by NOT gates, and operand B by XOR gates
// driven by the subtract control. The slice reports its carry out and
// its own overflow bit (carry into its top bit XOR carry out of it).
// Assumes W >= 2.
module adder_slice #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         inv_a,
    input  logic         sub_en,
    input  logic         c_in,
    output logic [W-1:0] s_out,
    output logic         c_out,
    output logic         v_out
);
    logic [W-1:0] a_eff;
    logic [W-1:0] b_eff;
    logic [W:0]   chain;

    assign chain[0] = c_in;

    // Per bit: operand shaping and a full adder cell.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign a_eff[i]    = a_in[i] ^ inv_a;
        assign b_eff[i]    = b_in[i] ^ sub_en;
        assign s_out[i]    = a_eff[i] ^ b_eff[i] ^ chain[i];
        assign chain[i+1]  = (a_eff[i] & b_eff[i]) | (chain[i] & (a_eff[i] ^ b_eff[i]));
    end

    assign c_out = chain[W];
    assign v_out = chain[W-1] ^ chain[W];
endmodule

// File: rtl/flag_unit.sv
// Derives the status flags from the sum, the raw operands and the
// carries leaving each slice.
// Assumes at least four slices.
module flag_unit #(
    parameter int DW = 16,
    parameter int NS = 4
) (
    input  logic [DW-1:0] sum,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic [NS-1:0] slice_c,
    input  logic          top_v,
    input  logic          cmp_unsigned,
    output logic          flg_c,
    output logic          flg_qc,
    output logic          flg_hc,
    output logic          flg_tc,
    output logic          flg_z,
    output logic          flg_eq,
    output logic          flg_n,
    output logic          flg_o
);
    localparam int Q = NS / 4;

    // Carry flags taken from slice boundaries.
    always_comb begin
        flg_c  = slice_c[NS-1];
        flg_qc = slice_c[Q-1];
        flg_hc = slice_c[2*Q-1];
        flg_tc = slice_c[3*Q-1];
    end

    // Result and operand comparisons.
    always_comb begin
        flg_z  = (sum == '0);
        flg_eq = (opa == opb);
        flg_o  = top_v;
        flg_n  = cmp_unsigned ? ~slice_c[NS-1] : sum[DW-1];
    end
endmodule

// File: rtl/sliced_adder16.sv
// Top of the sliced adder unit: chains SLICE_CNT slices carry-out to
// carry-in and attaches the flag unit. Purely combinational; the carry
// into the lowest slice is never derived from the subtract control.
module sliced_adder16
    import sliced_adder_pkg::*;
(
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              sub_en,
    input  logic              inv_a,
    input  logic              cin,
    input  logic              cmp_unsigned,
    output logic [DATA_W-1:0] res,
    output logic              flg_c,
    output logic              flg_qc,
    output logic              flg_hc,
    output logic              flg_tc,
    output logic              flg_z,
    output logic              flg_eq,
    output logic              flg_n,
    output logic              flg_o
);
    logic [SLICE_CNT:0]   carry;
    logic [SLICE_CNT-1:0] slice_v;

    assign carry[0] = cin;

    // Slice chain.
    for (genvar k = 0; k < SLICE_CNT; k++) begin : g_slice
        adder_slice #(.W(SLICE_W)) u_slice (
            .a_in  (opa[k*SLICE_W +: SLICE_W]),
            .b_in  (opb[k*SLICE_W +: SLICE_W]),
            .inv_a (inv_a),
            .sub_en(sub_en),
            .c_in  (carry[k]),
            .s_out (res[k*SLICE_W +: SLICE_W]),
            .c_out (carry[k+1]),
            .v_out (slice_v[k])
        );

        // Checks each slice's overflow bit against the sign rule on its own bits.
        always_comb begin
            // R9
            slice_ovf_chk: assert (slice_v[k] ==
                (((opa[(k+1)*SLICE_W-1] ^ inv_a) == (opb[(k+1)*SLICE_W-1] ^ sub_en)) &&
                 (res[(k+1)*SLICE_W-1] != (opa[(k+1)*SLICE_W-1] ^ inv_a))));
        end
    end

    flag_unit #(.DW(DATA_W), .NS(SLICE_CNT)) u_flags (
        .sum         (res),
        .opa         (opa),
        .opb         (opb),
        .slice_c     (carry[SLICE_CNT:1]),
        .top_v       (slice_v[SLICE_CNT-1]),
        .cmp_unsigned(cmp_unsigned),
        .flg_c       (flg_c),
        .flg_qc      (flg_qc),
        .flg_hc      (flg_hc),
        .flg_tc      (flg_tc),
        .flg_z       (flg_z),
        .flg_eq      (flg_eq),
        .flg_n       (flg_n),
        .flg_o       (flg_o)
    );

    // Cross-checks between the slice chain and the flag unit.
    always_comb begin
        // R1
        sum_arith_chk: assert ({flg_c, res} ==
            ({1'b0, (inv_a ? ~opa : opa)} + {1'b0, (opb ^ {DATA_W{sub_en}})} + {{DATA_W{1'b0}}, cin}));
        // R8
        unsigned_n_chk: assert (!cmp_unsigned || (flg_n != flg_c));
        // R6
        eq_sub_zero_chk: assert (!(flg_eq && sub_en && cin && !inv_a) || flg_z);
        // R5
        zero_sign_chk: assert (!flg_z || (!res[DATA_W-1] && (cmp_unsigned || !flg_n)));
    end
endmodule

// File: tb/sim_sliced_adder16.sv
module sim_sliced_adder16;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] opa = '0, opb = '0;
    logic        sub_en = 1'b0, inv_a = 1'b0, cin = 1'b0, cmp_unsigned = 1'b0;
    logic [15:0] res;
    logic        flg_c, flg_qc, flg_hc, flg_tc, flg_z, flg_eq, flg_n, flg_o;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    sliced_adder16 u0 (
        .opa(opa), .opb(opb), .sub_en(sub_en), .inv_a(inv_a), .cin(cin),
        .cmp_unsigned(cmp_unsigned), .res(res), .flg_c(flg_c), .flg_qc(flg_qc),
        .flg_hc(flg_hc), .flg_tc(flg_tc), .flg_z(flg_z), .flg_eq(flg_eq),
        .flg_n(flg_n), .flg_o(flg_o)
    );

    typedef struct packed {
        logic [15:0] a;
        logic [15:0] b;
        logic        sub;
        logic        inv;
        logic        ci;
        logic        uns;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0},
        '{16'h1234, 16'h4321, 1'b0, 1'b0, 1'b0, 1'b0},
        '{16'h000F, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0},
        '{16'h00F0, 16'h0010, 1'b0, 1'b0, 1'b0, 1'b0},
        '{16'h0F00, 16'h0100, 1'b0, 1'b0, 1'b0, 1'b0},
        '{16'hFFFF, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0},
        '{16'h8000, 16'h8000, 1'b0, 1'b0, 1'b0, 1'b0},
        '{16'h0005, 16'h0003, 1'b1, 1'b0, 1'b1, 1'b1},
        '{16'h0003, 16'h0005, 1'b1, 1'b0, 1'b1, 1'b1},
        '{16'h0003, 16'h0005, 1'b1, 1'b0, 1'b1, 1'b0},
        '{16'h8000, 16'h0001, 1'b1, 1'b0, 1'b1, 1'b0},
        '{16'h00FF, 16'h0001, 1'b0, 1'b1, 1'b0, 1'b0},
        '{16'hA5A5, 16'hA5A5, 1'b1, 1'b1, 1'b0, 1'b1},
        '{16'h7FFF, 16'h7FFF, 1'b0, 1'b0, 1'b1, 1'b0}
    };

    task automatic check1(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b (a=%h b=%h)", tag, act, exp, opa, opb);
        end
    endtask

    task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h (a=%h b=%h)", tag, act, exp, opa, opb);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        opa = v.a; opb = v.b; sub_en = v.sub; inv_a = v.inv; cin = v.ci; cmp_unsigned = v.uns;
        @(posedge clk);
        #1;
    endtask

    // Independent model: prefix sums in wide integers.
    task automatic check_model();
        logic [15:0] ea, eb;
        logic [16:0] full;
        logic [4:0]  p4;
        logic [8:0]  p8;
        logic [12:0] p12;
        logic        exp_o;
        ea   = inv_a ? ~opa : opa;
        eb   = opb ^ {16{sub_en}};
        full = {1'b0, ea} + {1'b0, eb} + {16'd0, cin};
        p4   = {1'b0, ea[3:0]} + {1'b0, eb[3:0]} + {4'd0, cin};
        p8   = {1'b0, ea[7:0]} + {1'b0, eb[7:0]} + {8'd0, cin};
        p12  = {1'b0, ea[11:0]} + {1'b0, eb[11:0]} + {12'd0, cin};
        exp_o = (ea[15] == eb[15]) && (full[15] != ea[15]);
        check16("R1 res", res, full[15:0]);
        check1("R3 flg_c", flg_c, full[16]);
        check1("R4 flg_qc", flg_qc, p4[4]);
        check1("R4 flg_hc", flg_hc, p8[8]);
        check1("R4 flg_tc", flg_tc, p12[12]);
        check1("R5 flg_z", flg_z, full[15:0] == 16'h0000);
        check1("R6 flg_eq", flg_eq, opa == opb);
        if (cmp_unsigned) check1("R8 flg_n", flg_n, ~full[16]);
        else              check1("R7 flg_n", flg_n, full[15]);
        check1("R9 flg_o", flg_o, exp_o);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // Idle state: all-zero inputs give zero result, Z and EQ set.
        #1;
        check16("R1 idle res", res, 16'h0000);
        check1("R5 idle flg_z", flg_z, 1'b1);
        check1("R6 idle flg_eq", flg_eq, 1'b1);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            check_model();
        end

        // R9: 32668 + 400 overflows to 16'h812C.
        apply('{16'd32668, 16'd400, 1'b0, 1'b0, 1'b0, 1'b0});
        check16("R9 ovf res", res, 16'h812C);
        check1("R9 ovf flg_o", flg_o, 1'b1);
        check1("R7 ovf flg_n", flg_n, 1'b1);

        // R2: subtract without carry-in yields A - B - 1.
        apply('{16'd100, 16'd40, 1'b1, 1'b0, 1'b0, 1'b0});
        check16("R2 sub no cin", res, 16'd59);
        apply('{16'd100, 16'd40, 1'b1, 1'b0, 1'b1, 1'b0});
        check16("R2 sub cin", res, 16'd60);
        check1("R3 sub borrow-free carry", flg_c, 1'b1);

        // R8: unsigned 3 - 5 borrows, so N set; signed mode gives sign bit.
        apply('{16'd3, 16'd5, 1'b1, 1'b0, 1'b1, 1'b1});
        check1("R8 uns below", flg_n, 1'b1);
        apply('{16'hFFFF, 16'h0001, 1'b1, 1'b0, 1'b1, 1'b1});
        check1("R8 uns above", flg_n, 1'b0);
        check1("R7 cross", res[15], 1'b1);

        // R6: equality ignores all controls.
        apply('{16'h5A5A, 16'h5A5A, 1'b0, 1'b1, 1'b1, 1'b1});
        check1("R6 eq ctrl", flg_eq, 1'b1);
        apply('{16'h5A5A, 16'h5A5B, 1'b1, 1'b0, 1'b1, 1'b0});
        check1("R6 neq", flg_eq, 1'b0);

        // R10: output follows an input change with no clock edge in between.
        @(negedge clk);
        opa = 16'h0010; opb = 16'h0020; sub_en = 0; inv_a = 0; cin = 0; cmp_unsigned = 0;
        #1;
        check16("R10 same cycle", res, 16'h0030);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule